// File: doc/BRIEF.md
# Time-of-Day Target Compare Engine

This block keeps a 64-bit free-running time-of-day counter and a 64-bit target time. Every cycle it checks whether the counter equals the target. On a match it emits a one-cycle event pulse, toggles a level output that can drive a pin, and sets a sticky interrupt status bit that is masked by an enable.

After each match the block computes the next target without host help. One mode copies the target from a preset register, so the host can stage the next trigger time ahead. The other mode adds that register to the target as a fixed interval, which gives a periodic event and a square wave on the pin output. All arithmetic wraps modulo 2^64.

The host writes through a 32-bit register port. Each 64-bit register (counter, target, interval/preset) is written as two 32-bit halves, and a register takes its new value only once both halves have arrived, in either order. The counter value is always visible on a 64-bit output.

Top module: `tod_target_cmp`

## Requirements
- R1: While reset is held, the outputs are as follows: tod_o is 0 and evt_o, pin_o, sts_o and irq_o are 0. The per-cycle increment resets to 1, the target resets to all ones, the interval/preset resets to 0, and the mode and enable bits reset to 0.
- R2: When no counter write commits in a cycle, tod_o advances by the 32-bit increment (address 7, zero-extended), modulo 2^64.
- R3: Counter, target and interval/preset are written through low/high half addresses: counter at 0/1, target at 2/3, interval/preset at 4/5. A write to one half alone changes nothing visible. The register takes {high, low} in the cycle the second half is written, whichever half that is. Both pending-half flags then clear.
- R4: evt_o is high for exactly the cycle that follows a cycle in which the counter equalled the target.
- R5: With the control mode bit (address 6, bit 0) at 1, a match loads the target from the interval/preset register.
- R6: With the mode bit at 0, a match adds the interval/preset register to the target, so events repeat every interval/increment cycles.
- R7: Both the counter and the target wrap past zero modulo 2^64, and the compare keeps working across the wrap.
- R8: Writing the counter to a value equal to the current target produces an event and sets the status bit.
- R9: pin_o toggles in each cycle in which evt_o is high and holds otherwise.
- R10: sts_o is set by every match. It is cleared by writing 1 in bit 0 of address 8, and a match in the same cycle wins over the clear. irq_o equals sts_o AND the enable bit (address 6, bit 1).
- R11: A counter write that commits replaces the increment in that cycle. A target write that commits replaces the post-match update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Register write data |
| tod_o | output | 64 | Current time-of-day counter |
| evt_o | output | 1 | One-cycle compare event pulse |
| pin_o | output | 1 | Level that toggles on each event |
| sts_o | output | 1 | Sticky match status |
| irq_o | output | 1 | Status masked by the enable bit |

## Verification
The bench aims at these corner cases:
- Half writes in both orders, including a lone half. A design that commits early would jump the counter.
- A counter write that lands exactly on the target. A design that checks only the increment path would miss this event.
- Wrap-around of both counter and target. Carry or width mistakes would lose the event after zero.
- Target commits in the same cycle as a match. If the post-match update won, the counter would later hit the wrong target.
- Random writes near the target, mixed with mode, enable and clear changes, are compared each cycle against a bench model of the pulse, pin, status and interrupt. This exposes wrong priority between set and clear, and double pulses.

// File: rtl/tod_cmp_pkg.sv
package tod_cmp_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_TOD_LO = 4'd0,
    A_TOD_HI = 4'd1,
    A_TGT_LO = 4'd2,
    A_TGT_HI = 4'd3,
    A_IVL_LO = 4'd4,
    A_IVL_HI = 4'd5,
    A_CTRL   = 4'd6,
    A_STEP   = 4'd7,
    A_ACK    = 4'd8
  } reg_addr_e;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
endpackage

// File: rtl/tod_half_stage.sv
module tod_half_stage #(
  parameter int HW      = 32,
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [HW-1:0]       wr_data,
  output logic                commit_o,
  output logic [2*HW-1:0]     word_o
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LO_ADDR + 1);

  logic [HW-1:0] lo_q, hi_q;
  logic          lo_v, hi_v;
  logic          lo_hit, hi_hit;

  assign lo_hit   = wr_en && (wr_addr == LO_A);
  assign hi_hit   = wr_en && (wr_addr == HI_A);
  assign commit_o = (lo_hit && hi_v) || (hi_hit && lo_v);
  assign word_o   = lo_hit ? {hi_q, wr_data} : {wr_data, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      lo_v <= 1'b0;
      hi_v <= 1'b0;
    end else if (commit_o) begin
      lo_v <= 1'b0;
      hi_v <= 1'b0;
    end else begin
      if (lo_hit) begin
        lo_q <= wr_data;
        lo_v <= 1'b1;
      end
      if (hi_hit) begin
        hi_q <= wr_data;
        hi_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int TW = 64,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic [SW-1:0] step_i,
  output logic [TW-1:0] tod_o
);
  always_ff @(posedge clk) begin
    if (rst)         tod_o <= '0;
    else if (load_i) tod_o <= load_val_i;
    else             tod_o <= tod_o + TW'(step_i);
  end
endmodule

// File: rtl/tod_target.sv
module tod_target #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_i,
  input  logic          reload_mode_i,
  input  logic [TW-1:0] ivl_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic [TW-1:0] tgt_o
);
  always_ff @(posedge clk) begin
    if (rst)              tgt_o <= '1;
    else if (load_i)      tgt_o <= load_val_i;
    else if (hit_i) begin
      if (reload_mode_i)  tgt_o <= ivl_i;
      else                tgt_o <= tgt_o + ivl_i;
    end
  end
endmodule

// File: rtl/tod_target_cmp.sv
module tod_target_cmp #(
  parameter int HW = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en_i,
  input  logic [tod_cmp_pkg::ADDR_W-1:0]  wr_addr_i,
  input  logic [HW-1:0]                   wr_data_i,
  output logic [2*HW-1:0]                 tod_o,
  output logic                            evt_o,
  output logic                            pin_o,
  output logic                            sts_o,
  output logic                            irq_o
);
  import tod_cmp_pkg::*;

  localparam int TW   = 2 * HW;
  localparam int NREG = 3;  // counter, target, interval/preset

  logic [NREG-1:0] commit;
  logic [TW-1:0]   word [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_stage
    tod_half_stage #(.HW(HW), .ADDR_W(ADDR_W), .LO_ADDR(2*g)) stage_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en_i),
      .wr_addr  (wr_addr_i),
      .wr_data  (wr_data_i),
      .commit_o (commit[g]),
      .word_o   (word[g])
    );
  end

  logic [TW-1:0] tgt_q, ivl_q;
  logic [HW-1:0] step_q;
  logic          mode_q, en_q;
  logic          hit, ctrl_wr, ack_clr, sts_n, en_n;

  assign hit     = (tod_o == tgt_q);
  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign ack_clr = wr_en_i && (wr_addr_i == A_ACK) && wr_data_i[0];
  assign sts_n   = hit || (sts_o && !ack_clr);
  assign en_n    = ctrl_wr ? wr_data_i[CTRL_EN_BIT] : en_q;

  tod_clock #(.TW(TW), .SW(HW)) clock_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (commit[0]),
    .load_val_i (word[0]),
    .step_i     (step_q),
    .tod_o      (tod_o)
  );

  tod_target #(.TW(TW)) target_i (
    .clk           (clk),
    .rst           (rst),
    .hit_i         (hit),
    .reload_mode_i (mode_q),
    .ivl_i         (ivl_q),
    .load_i        (commit[1]),
    .load_val_i    (word[1]),
    .tgt_o         (tgt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q  <= '0;
      step_q <= HW'(1);
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      evt_o  <= 1'b0;
      pin_o  <= 1'b0;
      sts_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (commit[2]) ivl_q <= word[2];
      if (wr_en_i && (wr_addr_i == A_STEP)) step_q <= wr_data_i;
      if (ctrl_wr) mode_q <= wr_data_i[CTRL_MODE_BIT];
      en_q  <= en_n;
      evt_o <= hit;
      pin_o <= pin_o ^ hit;
      sts_o <= sts_n;
      irq_o <= sts_n && en_n;
    end
  end
endmodule

// File: rtl/tod_target_cmp_chk.sv
module tod_target_cmp_chk #(
  parameter int TW = 64,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] tod,
  input logic [TW-1:0] tgt,
  input logic [SW-1:0] step,
  input logic          tod_load,
  input logic [TW-1:0] tod_load_val,
  input logic          en,
  input logic          evt,
  input logic          pin,
  input logic          sts,
  input logic          irq
);
  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(tod_load)) |-> (tod == $past(tod) + TW'($past(step))));

  // R11
  tod_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(tod_load)) |-> (tod == $past(tod_load_val)));

  // R4
  evt_match_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (evt == $past(tod == tgt)));

  // R9
  pin_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((pin != $past(pin)) == evt));

  // R10
  sts_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt |-> sts);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (sts && en));
endmodule

bind tod_target_cmp tod_target_cmp_chk #(.TW(2*HW), .SW(HW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .tod          (tod_o),
  .tgt          (tgt_q),
  .step         (step_q),
  .tod_load     (commit[0]),
  .tod_load_val (word[0]),
  .en           (en_q),
  .evt          (evt_o),
  .pin          (pin_o),
  .sts          (sts_o),
  .irq          (irq_o)
);

// File: tb/tod_target_cmp_tb_top.sv
`timescale 1ns/1ps
module tod_target_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [63:0] tod_o;
  logic        evt_o, pin_o, sts_o, irq_o;

  always #2.5 clk = ~clk;

  tod_target_cmp dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tod_o(tod_o), .evt_o(evt_o), .pin_o(pin_o), .sts_o(sts_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model of the requirements
  logic [63:0] m_tod, m_tgt, m_ivl;
  logic [31:0] m_step;
  logic        m_mode, m_en, m_sts, m_evt, m_pin, m_irq;
  logic [31:0] st_lo [3];
  logic [31:0] st_hi [3];
  bit          fl_lo [3];
  bit          fl_hi [3];

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_tod = '0; m_tgt = '1; m_ivl = '0; m_step = 32'd1;
    m_mode = 0; m_en = 0; m_sts = 0; m_evt = 0; m_pin = 0; m_irq = 0;
    for (int i = 0; i < 3; i++) begin
      st_lo[i] = '0; st_hi[i] = '0; fl_lo[i] = 0; fl_hi[i] = 0;
    end
  endfunction

  function automatic void model_step(bit we, logic [3:0] a, logic [31:0] d);
    bit          hit = (m_tod == m_tgt);
    bit          cm [3];
    logic [63:0] cv [3];
    bit          clr;
    for (int i = 0; i < 3; i++) begin
      bit lw = we && (a == 4'(2*i));
      bit hw = we && (a == 4'(2*i+1));
      cm[i] = (lw && fl_hi[i]) || (hw && fl_lo[i]);
      cv[i] = lw ? {st_hi[i], d} : {d, st_lo[i]};
      if (cm[i]) begin
        fl_lo[i] = 0; fl_hi[i] = 0;
      end else begin
        if (lw) begin st_lo[i] = d; fl_lo[i] = 1; end
        if (hw) begin st_hi[i] = d; fl_hi[i] = 1; end
      end
    end
    clr = we && (a == 4'd8) && d[0];
    m_sts = hit || (m_sts && !clr);
    if (cm[1])     m_tgt = cv[1];
    else if (hit)  m_tgt = m_mode ? m_ivl : m_tgt + m_ivl;
    m_tod = cm[0] ? cv[0] : m_tod + {32'd0, m_step};
    if (cm[2]) m_ivl = cv[2];
    if (we && a == 4'd7) m_step = d;
    if (we && a == 4'd6) begin m_mode = d[0]; m_en = d[1]; end
    m_evt = hit;
    m_pin = m_pin ^ hit;
    m_irq = m_sts && m_en;
  endfunction

  task automatic cyc(bit we, logic [3:0] a, logic [31:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    model_step(we, a, d);
    @(negedge clk);
    check64("R2 tod_o",  tod_o, m_tod);
    check64("R4 evt_o",  {63'd0, evt_o}, {63'd0, m_evt});
    check64("R9 pin_o",  {63'd0, pin_o}, {63'd0, m_pin});
    check64("R10 sts_o", {63'd0, sts_o}, {63'd0, m_sts});
    check64("R10 irq_o", {63'd0, irq_o}, {63'd0, m_irq});
  endtask

  task automatic wr64(logic [3:0] lo_a, logic [63:0] v, bit hi_first);
    if (hi_first) begin
      cyc(1, lo_a + 4'd1, v[63:32]); cyc(1, lo_a, v[31:0]);
    end else begin
      cyc(1, lo_a, v[31:0]); cyc(1, lo_a + 4'd1, v[63:32]);
    end
  endtask

  task automatic wait_evt(int lim, output int n);
    n = 0;
    do begin
      cyc(0, 4'd0, 32'd0);
      n++;
    end while (!evt_o && n < lim);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4711));
    wr_en = 0; wr_addr = '0; wr_data = '0; rst = 1;
    model_reset();
    repeat (4) @(negedge clk);
    // R1 reset state
    check64("R1 tod_o reset", tod_o, 64'd0);
    check64("R1 flags reset", {60'd0, evt_o, pin_o, sts_o, irq_o}, 64'd0);
    rst = 0;
    repeat (3) cyc(0, 4'd0, 32'd0);

    // R3 lone half, then commit by the other half
    cyc(1, 4'd1, 32'd1);
    check64("R3 lone half ignored", {32'd0, tod_o[63:32]}, 64'd0);
    cyc(0, 4'd0, 32'd0); cyc(0, 4'd0, 32'd0);
    check64("R3 still unchanged", {32'd0, tod_o[63:32]}, 64'd0);
    cyc(1, 4'd0, 32'h10);
    check64("R11 written value wins", tod_o, 64'h1_0000_0010);

    // R8 counter written onto target
    cyc(1, 4'd7, 32'd0);
    wr64(4'd4, 64'h100, 0);
    cyc(1, 4'd6, 32'h2);
    wr64(4'd2, 64'h1_0000_0050, 0);
    wr64(4'd0, 64'h1_0000_0050, 1);
    cyc(0, 4'd0, 32'd0);
    check64("R8 event on clock write", {63'd0, evt_o}, 64'd1);
    check64("R8 status set", {63'd0, sts_o}, 64'd1);
    cyc(0, 4'd0, 32'd0);
    check64("R4 single cycle pulse", {63'd0, evt_o}, 64'd0);

    // R6 periodic add mode: interval 0x100 / step 0x10 = 16 cycles
    cyc(1, 4'd7, 32'h10);
    wait_evt(100, n);
    wait_evt(100, n);
    check64("R6 period", 64'(n), 64'd16);
    wait_evt(100, n);
    check64("R6 period again", 64'(n), 64'd16);

    // R5 reload mode
    wr64(4'd4, 64'h1_0000_0900, 1);
    cyc(1, 4'd6, 32'h3);
    wait_evt(200, n);
    wait_evt(400, n);
    check64("R5 reloaded target", tod_o - 64'h10, 64'h1_0000_0900);

    // R7 wrap past zero
    cyc(1, 4'd6, 32'h2);
    cyc(1, 4'd7, 32'd1);
    wr64(4'd4, 64'd8, 0);
    wr64(4'd2, 64'hFFFF_FFFF_FFFF_FFFC, 1);
    wr64(4'd0, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    wait_evt(100, n);
    check64("R7 event before wrap", tod_o, 64'hFFFF_FFFF_FFFF_FFFD);
    wait_evt(100, n);
    check64("R7 gap across wrap", 64'(n), 64'd8);
    check64("R7 event after wrap", tod_o, 64'd5);

    // R10 mask and clear
    cyc(1, 4'd6, 32'h0);
    check64("R10 masked irq", {62'd0, sts_o, irq_o}, 64'b10);
    cyc(1, 4'd8, 32'h0);
    check64("R10 clear needs bit0", {63'd0, sts_o}, 64'd1);
    cyc(1, 4'd8, 32'h1);
    check64("R10 cleared", {63'd0, sts_o}, 64'd0);

    // R11 target commit beats the post-match update
    cyc(1, 4'd7, 32'd0);
    wr64(4'd0, 64'h10, 0);
    wr64(4'd2, 64'h2000, 0);
    cyc(1, 4'd2, 32'h7777);
    wr64(4'd0, 64'h2000, 1);
    cyc(1, 4'd3, 32'h0);
    check64("R8 match at written clock", {63'd0, evt_o}, 64'd1);
    wr64(4'd0, 64'h2008, 0);
    cyc(0, 4'd0, 32'd0);
    check64("R11 target commit wins", {63'd0, evt_o}, 64'd0);
    wr64(4'd0, 64'h7777, 0);
    cyc(0, 4'd0, 32'd0);
    check64("R11 committed target hits", {63'd0, evt_o}, 64'd1);

    // constrained random phase, compared each cycle with the model
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 100;
      logic [63:0] near = m_tgt - 64'($urandom % 6);
      if (r < 55)       cyc(0, 4'd0, 32'd0);
      else if (r < 65)  cyc(1, 4'($urandom % 2), ($urandom % 2) ? near[63:32] : near[31:0]);
      else if (r < 73)  cyc(1, 4'(2 + $urandom % 2), $urandom % 2 ? m_tod[63:32] : m_tod[31:0] + 32'd8);
      else if (r < 80)  cyc(1, 4'(4 + $urandom % 2), $urandom % 2 ? 32'd0 : $urandom % 40);
      else if (r < 86)  cyc(1, 4'd6, $urandom % 4);
      else if (r < 92)  cyc(1, 4'd7, $urandom % 3);
      else              cyc(1, 4'd8, $urandom % 2);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule